// File: doc/BRIEF.md
# ADC Sample and Conversion Sequencer

This block times one sample-and-convert sequence of a successive-approximation converter, counted in converter-clock cycles. It picks its start trigger from one of four sources, which are a software start bit and three timer outputs. The polarity of the chosen source can be flipped. The result passes through a two-flop synchronizer and an edge detector. A rising edge starts the sequence, which runs a one-cycle warm-up, a sample window, an eleven-cycle conversion phase and a single window-compare cycle. The sequence ends with a one-cycle done strobe.

The sample window can be set in two ways. In extended mode, the trigger's own high time sets the window. In pulse mode, an internal counter holds the window open for 4, 8, 16 or 64 cycles. The converter-core enable and the oscillator enable are high only while a sequence is in progress. Both rise one cycle ahead of sampling, so the clock has a ready margin. Mode and length are captured at the start edge. The analog sampling and the bit decisions are outside this block: conversion is a timed phase here.

Top module: `adc_seq_ctrl`

## Requirements
- R1: `trig_sel_i` picks the trigger source: 0 selects `sw_start_i`, and 1, 2 and 3 select `timer_trig_i[0]`, `[1]` and `[2]`. Activity on a source that is not selected never starts a sequence.
- R2: When `trig_inv_i` is 1, the selected source is inverted before edge detection, so a falling edge of the raw source starts a sequence.
- R3: Take the trigger going active before rising clock edge k. Then `busy_o`, `core_en_o` and `osc_en_o` rise at edge k+2. `samp_en_o` rises one cycle later, at edge k+3.
- R4: In extended mode (`pulse_mode_i`=0), a trigger held active for H cycles gives a sample window of max(H-1,1) cycles.
- R5: In pulse mode (`pulse_mode_i`=1), `samp_len_i` codes 0, 1, 2 and 3 give a sample window of 4, 8, 16 and 64 cycles. The trigger level after the start edge has no effect.
- R6: `conv_o` is high for exactly 11 cycles. It starts in the cycle right after `samp_en_o` falls.
- R7: `cmp_o` is high for exactly one cycle, right after the conversion phase.
- R8: `done_o` pulses for one cycle right after the compare cycle, and `busy_o` is already low in that cycle. Busy lasts (sample cycles + 13) cycles in total.
- R9: Rising trigger edges that arrive while `busy_o` is high are ignored. No new sequence follows them.
- R10: `core_en_o` and `osc_en_o` are low whenever `busy_o` is low.
- R11: After reset, all outputs are low.
- R12: `samp_en_o`, `conv_o` and `cmp_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Converter clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sw_start_i | input | 1 | Software start bit (source 0) |
| timer_trig_i | input | 3 | Timer trigger outputs (sources 1 to 3) |
| trig_sel_i | input | 2 | Trigger source select |
| trig_inv_i | input | 1 | Trigger polarity inversion |
| pulse_mode_i | input | 1 | 0 extended sample mode, 1 pulse mode |
| samp_len_i | input | 2 | Pulse-mode sample length code |
| samp_en_o | output | 1 | Sampling enable |
| conv_o | output | 1 | Conversion phase active |
| cmp_o | output | 1 | Window-compare cycle |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion strobe |
| core_en_o | output | 1 | Converter-core power enable |
| osc_en_o | output | 1 | Oscillator enable |

## Verification
The bench drives a trigger on a falling clock edge and samples every output on each following falling edge. It counts those samples from 1. Busy and both enables are due at sample 3 and the sample window at sample 4. The conversion starts at 4 plus the window length, the compare cycle follows 11 samples later, and done comes one sample after that. Each run records the sample index at which every phase first appears and how long it lasts, and compares these with values computed from the mode, length code or hold time. After done, the bench waits a few more samples, with the trigger still active and a new edge already sent during the run, to confirm that busy stays low.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WARM,
    ST_SAMPLE,
    ST_CONV,
    ST_CMP
  } seq_state_e;
endpackage

// File: rtl/adc_trig_front.sv
module adc_trig_front #(
  parameter int unsigned NUM_SRC     = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned SEL_W      = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               inv_i,
  output logic               lvl_o,
  output logic               rise_o
);
  logic                   raw;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  assign raw = src_i[sel_i] ^ inv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign lvl_o  = sync_q[SYNC_STAGES-1];
  assign rise_o = lvl_o & ~prev_q;
endmodule

// File: rtl/adc_phase_cnt.sv
module adc_phase_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (en_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned CONV_CYCLES = 11,
  parameter int unsigned SAMP_LEN0   = 4,
  parameter int unsigned SAMP_LEN1   = 8,
  parameter int unsigned SAMP_LEN2   = 16,
  parameter int unsigned SAMP_LEN3   = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             lvl_i,
  input  logic             pulse_mode_i,
  input  logic [1:0]       samp_len_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             cnt_clr_o,
  output logic             cnt_en_o,
  output logic             samp_en_o,
  output logic             conv_o,
  output logic             cmp_o,
  output logic             busy_o,
  output logic             done_o
);
  seq_state_e       state_q, state_d;
  logic             mode_q;
  logic [1:0]       len_q;
  logic [CNT_W-1:0] len_last;
  logic             samp_end;
  logic             done_q;

  always_comb begin
    unique case (len_q)
      2'd0:    len_last = CNT_W'(SAMP_LEN0 - 1);
      2'd1:    len_last = CNT_W'(SAMP_LEN1 - 1);
      2'd2:    len_last = CNT_W'(SAMP_LEN2 - 1);
      default: len_last = CNT_W'(SAMP_LEN3 - 1);
    endcase
  end

  // extended mode: window closes when synchronized trigger drops
  assign samp_end = mode_q ? (cnt_i == len_last) : !lvl_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (rise_i) state_d = ST_WARM;
      ST_WARM:   state_d = ST_SAMPLE;
      ST_SAMPLE: if (samp_end) state_d = ST_CONV;
      ST_CONV:   if (cnt_i == CNT_W'(CONV_CYCLES - 1)) state_d = ST_CMP;
      ST_CMP:    state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b0;
      len_q   <= 2'd0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_CMP);
      if (state_q == ST_IDLE && rise_i) begin
        mode_q <= pulse_mode_i;
        len_q  <= samp_len_i;
      end
    end
  end

  assign cnt_clr_o = (state_d != state_q);
  assign cnt_en_o  = (state_q != ST_IDLE);
  assign samp_en_o = (state_q == ST_SAMPLE);
  assign conv_o    = (state_q == ST_CONV);
  assign cmp_o     = (state_q == ST_CMP);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int unsigned NUM_TIMERS  = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CONV_CYCLES = 11,
  parameter int unsigned SAMP_LEN0   = 4,
  parameter int unsigned SAMP_LEN1   = 8,
  parameter int unsigned SAMP_LEN2   = 16,
  parameter int unsigned SAMP_LEN3   = 64,
  localparam int unsigned NUM_SRC    = NUM_TIMERS + 1,
  localparam int unsigned SEL_W      = $clog2(NUM_SRC),
  localparam int unsigned MAX_CNT    = (SAMP_LEN3 > CONV_CYCLES) ? SAMP_LEN3 : CONV_CYCLES,
  localparam int unsigned CNT_W      = $clog2(MAX_CNT) + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sw_start_i,
  input  logic [NUM_TIMERS-1:0] timer_trig_i,
  input  logic [SEL_W-1:0]      trig_sel_i,
  input  logic                  trig_inv_i,
  input  logic                  pulse_mode_i,
  input  logic [1:0]            samp_len_i,
  output logic                  samp_en_o,
  output logic                  conv_o,
  output logic                  cmp_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  core_en_o,
  output logic                  osc_en_o
);
  logic             trig_lvl, trig_rise;
  logic             cnt_clr, cnt_en;
  logic [CNT_W-1:0] cnt;

  adc_trig_front #(
    .NUM_SRC    (NUM_SRC),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_front (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .src_i ({timer_trig_i, sw_start_i}),
    .sel_i (trig_sel_i),
    .inv_i (trig_inv_i),
    .lvl_o (trig_lvl),
    .rise_o(trig_rise)
  );

  adc_phase_cnt #(.W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (cnt_en),
    .clr_i (cnt_clr),
    .cnt_o (cnt)
  );

  adc_seq_fsm #(
    .CNT_W      (CNT_W),
    .CONV_CYCLES(CONV_CYCLES),
    .SAMP_LEN0  (SAMP_LEN0),
    .SAMP_LEN1  (SAMP_LEN1),
    .SAMP_LEN2  (SAMP_LEN2),
    .SAMP_LEN3  (SAMP_LEN3)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rise_i      (trig_rise),
    .lvl_i       (trig_lvl),
    .pulse_mode_i(pulse_mode_i),
    .samp_len_i  (samp_len_i),
    .cnt_i       (cnt),
    .cnt_clr_o   (cnt_clr),
    .cnt_en_o    (cnt_en),
    .samp_en_o   (samp_en_o),
    .conv_o      (conv_o),
    .cmp_o       (cmp_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  // core and oscillator run only while a sequence is active
  assign core_en_o = busy_o;
  assign osc_en_o  = busy_o;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int unsigned CONV_CYCLES = 11,
  localparam int unsigned RUN_W      = $clog2(CONV_CYCLES + 1) + 1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic samp_en_o,
  input logic conv_o,
  input logic cmp_o,
  input logic busy_o,
  input logic done_o,
  input logic core_en_o,
  input logic osc_en_o
);
  logic [RUN_W-1:0] conv_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     conv_run <= '0;
    else if (conv_o) conv_run <= conv_run + 1'b1;
    else             conv_run <= '0;
  end

  a_r12_phase_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({samp_en_o, conv_o, cmp_o}));

  a_r10_idle_power_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!core_en_o && !osc_en_o));

  a_r3_sample_powered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_en_o |-> (core_en_o && osc_en_o && busy_o));

  a_r3_osc_margin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(samp_en_o) |-> $past(osc_en_o));

  a_r6_conv_after_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(samp_en_o) |-> conv_o);

  a_r6_conv_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(conv_o) |-> (cmp_o && conv_run == RUN_W'(CONV_CYCLES)));

  a_r7_cmp_then_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_o |=> (!cmp_o && done_o));

  a_r8_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .samp_en_o(samp_en_o),
  .conv_o   (conv_o),
  .cmp_o    (cmp_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .core_en_o(core_en_o),
  .osc_en_o (osc_en_o)
);

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] src = 4'b0;
  logic [1:0] trig_sel_i = 2'd0;
  logic       trig_inv_i = 1'b0;
  logic       pulse_mode_i = 1'b0;
  logic [1:0] samp_len_i = 2'd0;
  logic samp_en_o, conv_o, cmp_o, busy_o, done_o, core_en_o, osc_en_o;

  int errors = 0;
  int checks = 0;

  always #4 clk_i = ~clk_i;

  adc_seq_ctrl u_adc_seq_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sw_start_i  (src[0]),
    .timer_trig_i(src[3:1]),
    .trig_sel_i  (trig_sel_i),
    .trig_inv_i  (trig_inv_i),
    .pulse_mode_i(pulse_mode_i),
    .samp_len_i  (samp_len_i),
    .samp_en_o   (samp_en_o),
    .conv_o      (conv_o),
    .cmp_o       (cmp_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .core_en_o   (core_en_o),
    .osc_en_o    (osc_en_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one full sequence; hold = trigger active cycles in extended mode
  task automatic run_seq(input int sel, input bit inv, input bit pmode,
                         input int lcode, input int hold);
    int exp_samp;
    int busy_first = -1, samp_first = -1, conv_first = -1, cmp_idx = -1, done_idx = -1;
    int samp_cnt = 0, conv_cnt = 0, cmp_cnt = 0, done_cnt = 0, busy_cnt = 0;
    int osc_at3 = 0, pwr_bad = 0, ovl_bad = 0, stray = 0, post_busy = 0;
    @(negedge clk_i);
    trig_sel_i   = 2'(sel);
    trig_inv_i   = inv;
    pulse_mode_i = pmode;
    samp_len_i   = 2'(lcode);
    src          = {4{inv}};
    repeat (4) @(negedge clk_i);
    // R1: toggle every unselected source
    for (int b = 0; b < 4; b++) if (b != sel) src[b] = ~inv;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      if (busy_o) stray++;
      if (i == 2) src = {4{inv}};
    end
    chk(stray == 0, "R1 unselected source started sequence", stray, 0);
    src[sel] = ~inv;
    if (pmode) exp_samp = (lcode == 3) ? 64 : (4 << lcode);
    else       exp_samp = (hold > 2) ? hold - 1 : 1;
    for (int i = 1; i < 200 && done_idx < 0; i++) begin
      @(negedge clk_i);
      if (busy_o) begin busy_cnt++; if (busy_first < 0) busy_first = i; end
      if (samp_en_o) begin samp_cnt++; if (samp_first < 0) samp_first = i; end
      if (conv_o) begin conv_cnt++; if (conv_first < 0) conv_first = i; end
      if (cmp_o) begin cmp_cnt++; cmp_idx = i; end
      if (done_o) begin done_cnt++; done_idx = i; if (busy_o) pwr_bad++; end
      if (i == 3 && osc_en_o && core_en_o) osc_at3 = 1;
      if (!busy_o && (core_en_o || osc_en_o)) pwr_bad++;
      if (int'(samp_en_o) + int'(conv_o) + int'(cmp_o) > 1) ovl_bad++;
      if (!pmode && i == hold) src[sel] = inv;
      if (pmode && i == 8) src[sel] = inv;   // R9: re-arm edge while busy
      if (pmode && i == 9) src[sel] = ~inv;
    end
    chk(busy_first == 3, "R3 busy rise index", busy_first, 3);
    chk(osc_at3 == 1, "R3 core/osc enable at busy rise", osc_at3, 1);
    chk(samp_first == 4, "R3 sample start index", samp_first, 4);
    chk(samp_cnt == exp_samp, pmode ? "R5 pulse window" : "R4 extended window",
        samp_cnt, exp_samp);
    chk(conv_cnt == 11, "R6 conversion length", conv_cnt, 11);
    chk(conv_first == 4 + exp_samp, "R6 conversion start", conv_first, 4 + exp_samp);
    chk(cmp_cnt == 1 && cmp_idx == conv_first + 11, "R7 compare cycle", cmp_idx, conv_first + 11);
    chk(done_cnt == 1 && done_idx == cmp_idx + 1, "R8 done strobe", done_idx, cmp_idx + 1);
    chk(busy_cnt == exp_samp + 13, "R8 busy length", busy_cnt, exp_samp + 13);
    chk(pwr_bad == 0, "R10 power while idle", pwr_bad, 0);
    chk(ovl_bad == 0, "R12 phase overlap", ovl_bad, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      if (busy_o || done_o) post_busy++;
    end
    chk(post_busy == 0, "R9 edge during busy restarted", post_busy, 0);
    src = {4{inv}};
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk({samp_en_o, conv_o, cmp_o, busy_o, done_o, core_en_o, osc_en_o} == 7'b0,
        "R11 outputs in reset", {samp_en_o, conv_o, cmp_o, busy_o, done_o, core_en_o, osc_en_o}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk({samp_en_o, conv_o, cmp_o, busy_o, done_o, core_en_o, osc_en_o} == 7'b0,
        "R11 outputs after reset", {samp_en_o, conv_o, cmp_o, busy_o, done_o, core_en_o, osc_en_o}, 0);
    // pulse mode sweep, inverted polarity covers R2
    for (int s = 0; s < 4; s++)
      for (int v = 0; v < 2; v++)
        for (int l = 0; l < 4; l++)
          run_seq(s, v[0], 1'b1, l, 0);
    // extended mode sweep over hold times
    for (int h = 1; h <= 14; h++)
      run_seq(h % 4, h[1], 1'b0, 0, h);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule